// File: doc/BRIEF.md
# Tag-Row Lookup Buffer for an In-Row-Tagged DRAM Cache

This block sits in front of the request port of a DRAM cache controller. The cache keeps the tags of its blocks inside the same DRAM row as the data. Without help, every lookup first reads that row's tags and then reads the data. The block keeps a small direct-mapped SRAM buffer. Each entry holds the complete tag set of one recently used DRAM row. A load whose row is in the buffer gets its cache hit or miss decided on acceptance and causes one data access.

A load whose row is absent first causes a metadata read of that row. The block installs the returned tag set, replacing whatever occupied that buffer slot, and then issues the data access. That access is flagged as landing on the row that is already open. Fills and evictions elsewhere in the controller report each tag change on an update port, so that buffered copies stay equal to the tags held in the rows. Only one load is handled at a time. Cache blocks are 128 bytes, so the load port carries block addresses only.

Top module: `tmb_top`

## Requirements
- R1: After reset `ld_ready` is 1, `mem_req_valid` is 0 and no buffer entry is valid, so the first load to any row causes a metadata read.
- R2: `ld_addr` is a block address laid out as {tag, row, slot}: `SLOT_W` low bits select the block within the row, the next `ROW_W` bits give the DRAM row, and the top `TAG_W` bits are the tag. The buffer entry index is the low `IDX_W` bits of the row, so two rows that share those bits evict each other.
- R3: When a load is accepted and its row is in the buffer, the next cycle presents exactly one data request (`mem_req_meta`=0, `mem_req_openrow`=0) for that row and slot.
- R4: When a load is accepted and its row is not in the buffer, the next cycle presents a metadata request (`mem_req_meta`=1) for that row.
- R5: The metadata response packs slot j into bits [j*(TAG_W+1) +: TAG_W+1] as {valid, tag}. The cycle after `meta_rsp_valid`, the block presents a data request with `mem_req_openrow`=1 for the same row and slot. The response is installed in the row's buffer entry, and later loads to that row hit in the buffer.
- R6: On a data request, `mem_req_dchit` is 1 exactly when the slot's tag is valid and equals the load's tag. The tag set used is the buffered one on a buffer hit and the returned one after a metadata read.
- R7: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with row, slot and kind unchanged.
- R8: `ld_ready` is 1 only while no load is in progress. A load presented while busy is ignored and produces no request.
- R9: An update (`upd_valid`) rewrites that slot's {valid, tag} in the buffer entry of `upd_row` in the same cycle, if the entry holds that row. An update to a row that is not buffered leaves the buffer unchanged.
- R10: The cycle after a data request is accepted, the block is idle again (`ld_ready`=1, `mem_req_valid`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Block idle, load accepted this cycle |
| ld_addr | input | TAG_W+ROW_W+SLOT_W | Block address {tag, row, slot} |
| mem_req_valid | output | 1 | Request to DRAM controller |
| mem_req_ready | input | 1 | DRAM controller takes request |
| mem_req_meta | output | 1 | 1 = metadata read of row, 0 = data access |
| mem_req_row | output | ROW_W | DRAM row of the request |
| mem_req_slot | output | SLOT_W | Block slot within the row |
| mem_req_dchit | output | 1 | DRAM-cache hit decision (data requests) |
| mem_req_openrow | output | 1 | Data access follows a metadata read of the same row |
| meta_rsp_valid | input | 1 | Metadata read data returned |
| meta_rsp_tags | input | SLOTS*(TAG_W+1) | Returned tag set, slot j = {valid, tag} |
| upd_valid | input | 1 | Tag change from fill/eviction |
| upd_row | input | ROW_W | Row of the changed block |
| upd_slot | input | SLOT_W | Slot of the changed block |
| upd_tag | input | TAG_W | New tag |
| upd_vld | input | 1 | New valid bit |

## Verification
The bench builds the block with 8 buffer entries, 64 rows, 4 slots per row and 3-bit tags. With these values random loads revisit buffered rows often and collide on shared index bits often, and random tags match stored tags often enough to produce both cache decisions. This brings eviction by a conflicting row, installs that overwrite a stale occupant, and updates to absent rows into frequent reach. The bench also stalls the request port for random spans and issues loads while busy.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int unsigned TMB_ROW_W   = 10;
  localparam int unsigned TMB_SLOTS   = 4;
  localparam int unsigned TMB_TAG_W   = 6;
  localparam int unsigned TMB_ENTRIES = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_DATA  = 2'd3
  } tmb_state_e;
endpackage

// File: rtl/tmb_store.sv
module tmb_store #(
  parameter int unsigned ROW_W   = tmb_pkg::TMB_ROW_W,
  parameter int unsigned SLOTS   = tmb_pkg::TMB_SLOTS,
  parameter int unsigned TAG_W   = tmb_pkg::TMB_TAG_W,
  parameter int unsigned ENTRIES = tmb_pkg::TMB_ENTRIES,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned RTAG_W = ROW_W - IDX_W,
  localparam int unsigned MW     = SLOTS * (TAG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_present,
  output logic [MW-1:0]     lk_meta,
  input  logic              ins_en,
  input  logic [ROW_W-1:0]  ins_row,
  input  logic [MW-1:0]     ins_meta,
  input  logic              upd_en,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic              upd_vld
);
  function automatic logic [IDX_W-1:0] idx_of(input logic [ROW_W-1:0] r);
    return r[IDX_W-1:0];
  endfunction

  function automatic logic [RTAG_W-1:0] rtag_of(input logic [ROW_W-1:0] r);
    return r[ROW_W-1:IDX_W];
  endfunction

  logic              ent_v  [ENTRIES];
  logic [RTAG_W-1:0] ent_rt [ENTRIES];
  logic [MW-1:0]     ent_m  [ENTRIES];

  logic [IDX_W-1:0] li, ii, ui;
  logic             ins_same_row, upd_hit;
  logic [MW-1:0]    upd_merged;

  assign li = idx_of(lk_row);
  assign ii = idx_of(ins_row);
  assign ui = idx_of(upd_row);

  assign lk_present = ent_v[li] && (ent_rt[li] == rtag_of(lk_row));
  assign lk_meta    = ent_m[li];

  assign ins_same_row = ins_en && (ins_row == upd_row);
  assign upd_hit = upd_en && (ins_same_row ||
                   (ent_v[ui] && (ent_rt[ui] == rtag_of(upd_row)) &&
                    !(ins_en && (ii == ui))));

  always_comb begin
    upd_merged = ins_same_row ? ins_meta : ent_m[ui];
    upd_merged[upd_slot*(TAG_W+1) +: (TAG_W+1)] = {upd_vld, upd_tag};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else begin
      if (ins_en) begin
        ent_v[ii]  <= 1'b1;
        ent_rt[ii] <= rtag_of(ins_row);
        ent_m[ii]  <= ins_meta;
      end
      if (upd_hit) ent_m[ui] <= upd_merged;
    end
  end
endmodule

// File: rtl/tmb_ctrl.sv
module tmb_ctrl #(
  parameter int unsigned ROW_W  = tmb_pkg::TMB_ROW_W,
  parameter int unsigned SLOTS  = tmb_pkg::TMB_SLOTS,
  parameter int unsigned TAG_W  = tmb_pkg::TMB_TAG_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned MW     = SLOTS * (TAG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [SLOT_W-1:0] ld_slot,
  output logic              ld_ready,
  input  logic              lk_present,
  input  logic [MW-1:0]     lk_meta,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_meta,
  output logic [ROW_W-1:0]  mem_req_row,
  output logic [SLOT_W-1:0] mem_req_slot,
  output logic              mem_req_dchit,
  output logic              mem_req_openrow,
  input  logic              meta_rsp_valid,
  input  logic [MW-1:0]     meta_rsp_tags,
  output logic              ins_en,
  output logic [ROW_W-1:0]  ins_row,
  output logic [MW-1:0]     ins_meta
);
  import tmb_pkg::*;

  function automatic logic dc_hit(input logic [MW-1:0] m,
                                  input logic [SLOT_W-1:0] s,
                                  input logic [TAG_W-1:0] t);
    logic [TAG_W:0] e;
    e = m[s*(TAG_W+1) +: (TAG_W+1)];
    return e[TAG_W] && (e[TAG_W-1:0] == t);
  endfunction

  tmb_state_e        state;
  logic [ROW_W-1:0]  row_q;
  logic [SLOT_W-1:0] slot_q;
  logic [TAG_W-1:0]  tag_q;
  logic              hit_q, open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      row_q  <= '0;
      slot_q <= '0;
      tag_q  <= '0;
      hit_q  <= 1'b0;
      open_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (ld_valid) begin
          row_q  <= ld_row;
          slot_q <= ld_slot;
          tag_q  <= ld_tag;
          open_q <= 1'b0;
          hit_q  <= lk_present && dc_hit(lk_meta, ld_slot, ld_tag);
          state  <= lk_present ? ST_DATA : ST_MREQ;
        end
        ST_MREQ: if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: if (meta_rsp_valid) begin
          hit_q  <= dc_hit(meta_rsp_tags, slot_q, tag_q);
          open_q <= 1'b1;
          state  <= ST_DATA;
        end
        ST_DATA: if (mem_req_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ld_ready        = (state == ST_IDLE);
  assign mem_req_valid   = (state == ST_MREQ) || (state == ST_DATA);
  assign mem_req_meta    = (state == ST_MREQ);
  assign mem_req_row     = row_q;
  assign mem_req_slot    = slot_q;
  assign mem_req_dchit   = (state == ST_DATA) && hit_q;
  assign mem_req_openrow = (state == ST_DATA) && open_q;
  assign ins_en          = (state == ST_MWAIT) && meta_rsp_valid;
  assign ins_row         = row_q;
  assign ins_meta        = meta_rsp_tags;
endmodule

// File: rtl/tmb_top.sv
module tmb_top #(
  parameter int unsigned ROW_W   = tmb_pkg::TMB_ROW_W,
  parameter int unsigned SLOTS   = tmb_pkg::TMB_SLOTS,
  parameter int unsigned TAG_W   = tmb_pkg::TMB_TAG_W,
  parameter int unsigned ENTRIES = tmb_pkg::TMB_ENTRIES,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned MW     = SLOTS * (TAG_W + 1),
  localparam int unsigned ADDR_W = TAG_W + ROW_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_meta,
  output logic [ROW_W-1:0]  mem_req_row,
  output logic [SLOT_W-1:0] mem_req_slot,
  output logic              mem_req_dchit,
  output logic              mem_req_openrow,
  input  logic              meta_rsp_valid,
  input  logic [MW-1:0]     meta_rsp_tags,
  input  logic              upd_valid,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic              upd_vld
);
  logic [TAG_W-1:0]  ld_tag;
  logic [ROW_W-1:0]  ld_row;
  logic [SLOT_W-1:0] ld_slot;

  assign ld_slot = ld_addr[SLOT_W-1:0];
  assign ld_row  = ld_addr[SLOT_W +: ROW_W];
  assign ld_tag  = ld_addr[SLOT_W+ROW_W +: TAG_W];

  // Named internal events, observed by the bound checker
  logic              ev_bufhit;
  logic              ev_install;
  logic [MW-1:0]     lk_meta;
  logic [ROW_W-1:0]  ins_row;
  logic [MW-1:0]     ins_meta;

  tmb_store #(.ROW_W(ROW_W), .SLOTS(SLOTS), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_row(ld_row), .lk_present(ev_bufhit), .lk_meta(lk_meta),
    .ins_en(ev_install), .ins_row(ins_row), .ins_meta(ins_meta),
    .upd_en(upd_valid), .upd_row(upd_row), .upd_slot(upd_slot),
    .upd_tag(upd_tag), .upd_vld(upd_vld)
  );

  tmb_ctrl #(.ROW_W(ROW_W), .SLOTS(SLOTS), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_row(ld_row), .ld_slot(ld_slot),
    .ld_ready(ld_ready),
    .lk_present(ev_bufhit), .lk_meta(lk_meta),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_meta(mem_req_meta), .mem_req_row(mem_req_row),
    .mem_req_slot(mem_req_slot), .mem_req_dchit(mem_req_dchit),
    .mem_req_openrow(mem_req_openrow),
    .meta_rsp_valid(meta_rsp_valid), .meta_rsp_tags(meta_rsp_tags),
    .ins_en(ev_install), .ins_row(ins_row), .ins_meta(ins_meta)
  );
endmodule

// File: rtl/tmb_chk.sv
module tmb_chk #(
  parameter int unsigned ROW_W  = 10,
  parameter int unsigned SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_meta,
  input logic [ROW_W-1:0]  mem_req_row,
  input logic [SLOT_W-1:0] mem_req_slot,
  input logic              mem_req_openrow,
  input logic              ev_bufhit,
  input logic              ev_install
);
  AST_HIT_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && ev_bufhit) |=> (mem_req_valid && !mem_req_meta && !mem_req_openrow)); // R3
  AST_MISS_META_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !ev_bufhit) |=> (mem_req_valid && mem_req_meta)); // R4
  AST_INSTALL_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_install |=> (mem_req_valid && !mem_req_meta && mem_req_openrow &&
                    mem_req_row == $past(mem_req_row))); // R5
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_meta) &&
                    $stable(mem_req_row) && $stable(mem_req_slot))); // R7
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !ld_ready); // R8
  AST_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_meta) |=> (ld_ready && !mem_req_valid)); // R10
endmodule

bind tmb_top tmb_chk #(.ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_meta(mem_req_meta), .mem_req_row(mem_req_row),
  .mem_req_slot(mem_req_slot), .mem_req_openrow(mem_req_openrow),
  .ev_bufhit(ev_bufhit), .ev_install(ev_install)
);

// File: tb/tmb_top_bench.sv
module tmb_top_bench;
  localparam int ROW_W = 6, SLOTS = 4, TAG_W = 3, ENTRIES = 8;
  localparam int SLOT_W = 2, NROWS = 64, EW = TAG_W + 1, MW = SLOTS * EW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, mem_req_ready = 1'b0, meta_rsp_valid = 1'b0, upd_valid = 1'b0;
  logic [TAG_W+ROW_W+SLOT_W-1:0] ld_addr = '0;
  logic [MW-1:0] meta_rsp_tags = '0;
  logic [ROW_W-1:0] upd_row = '0;
  logic [SLOT_W-1:0] upd_slot = '0;
  logic [TAG_W-1:0] upd_tag = '0;
  logic upd_vld = 1'b0;
  logic ld_ready, mem_req_valid, mem_req_meta, mem_req_dchit, mem_req_openrow;
  logic [ROW_W-1:0] mem_req_row;
  logic [SLOT_W-1:0] mem_req_slot;

  always #10 clk = ~clk;

  tmb_top #(.ROW_W(ROW_W), .SLOTS(SLOTS), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_tmb_top (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_meta(mem_req_meta),
    .mem_req_row(mem_req_row), .mem_req_slot(mem_req_slot), .mem_req_dchit(mem_req_dchit),
    .mem_req_openrow(mem_req_openrow), .meta_rsp_valid(meta_rsp_valid),
    .meta_rsp_tags(meta_rsp_tags), .upd_valid(upd_valid), .upd_row(upd_row),
    .upd_slot(upd_slot), .upd_tag(upd_tag), .upd_vld(upd_vld));

  // Reference state: tags held in each DRAM row, and the expected buffer contents
  logic [MW-1:0]    dram_tags [NROWS];
  bit               mb_v   [ENTRIES];
  logic [ROW_W-1:0] mb_row [ENTRIES];
  logic [MW-1:0]    mb_tags[ENTRIES];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_dchit(input logic [MW-1:0] m, input int sl, input int tg);
    int e;
    e = int'((m >> (sl * EW)) & ((1 << EW) - 1));
    return (e >= (1 << TAG_W)) && ((e % (1 << TAG_W)) == tg);
  endfunction

  function automatic logic [MW-1:0] set_slot(input logic [MW-1:0] m, input int sl,
                                             input int tg, input bit v);
    logic [MW-1:0] mask, val;
    mask = MW'((1 << EW) - 1) << (sl * EW);
    val  = MW'(v * (1 << TAG_W) + tg) << (sl * EW);
    return (m & ~mask) | val;
  endfunction

  task automatic stall(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [ROW_W-1:0] r0;
      logic m0;
      r0 = mem_req_row; m0 = mem_req_meta;
      @(negedge clk);
      chk(mem_req_valid && mem_req_row == r0 && mem_req_meta == m0, req,
          {mem_req_valid, mem_req_meta}, {1'b1, m0});
    end
  endtask

  task automatic do_load(input int tg, input int rw, input int sl, input bit busy_poke);
    int idx;
    bit miss;
    logic [MW-1:0] m;
    idx  = rw % ENTRIES;
    miss = !(mb_v[idx] && mb_row[idx] == ROW_W'(rw));
    @(negedge clk);
    ld_valid = 1'b1;
    ld_addr  = {TAG_W'(tg), ROW_W'(rw), SLOT_W'(sl)};
    @(negedge clk);
    ld_valid = 1'b0;
    chk(mem_req_valid && mem_req_meta == miss, miss ? "R4 metadata read on miss" : "R3 direct data on hit",
        {mem_req_valid, mem_req_meta}, {1'b1, miss});
    chk(mem_req_row == ROW_W'(rw) && mem_req_slot == SLOT_W'(sl), "R2 row/slot fields",
        mem_req_row, rw);
    if (miss) begin
      stall($urandom_range(0, 2), "R7 metadata request held");
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(!mem_req_valid && !ld_ready, "R8 waiting for tags", mem_req_valid, 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      meta_rsp_valid = 1'b1;
      meta_rsp_tags  = dram_tags[rw];
      @(negedge clk);
      meta_rsp_valid = 1'b0;
      m = dram_tags[rw];
      mb_v[idx] = 1'b1; mb_row[idx] = ROW_W'(rw); mb_tags[idx] = m;
      chk(mem_req_valid && !mem_req_meta && mem_req_openrow && mem_req_row == ROW_W'(rw),
          "R5 open-row data after install", {mem_req_valid, mem_req_meta, mem_req_openrow}, 3'b101);
    end else begin
      m = mb_tags[idx];
      chk(!mem_req_openrow, "R3 no open-row flag on buffer hit", mem_req_openrow, 0);
    end
    chk(mem_req_dchit == exp_dchit(m, sl, tg), "R6 cache hit decision", mem_req_dchit,
        exp_dchit(m, sl, tg));
    if (busy_poke) begin
      ld_valid = 1'b1;
      ld_addr  = ld_addr ^ {{(TAG_W+ROW_W){1'b1}}, {SLOT_W{1'b0}}};
      @(negedge clk);
      ld_valid = 1'b0;
      chk(!ld_ready && mem_req_valid && !mem_req_meta && mem_req_row == ROW_W'(rw),
          "R8 load while busy ignored", mem_req_row, rw);
    end
    stall($urandom_range(0, 2), "R7 data request held");
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(ld_ready && !mem_req_valid, "R10 idle after data accepted", {ld_ready, mem_req_valid}, 2'b10);
  endtask

  task automatic do_upd(input int rw, input int sl, input int tg, input bit v);
    int idx;
    idx = rw % ENTRIES;
    @(negedge clk);
    upd_valid = 1'b1; upd_row = ROW_W'(rw); upd_slot = SLOT_W'(sl);
    upd_tag = TAG_W'(tg); upd_vld = v;
    @(negedge clk);
    upd_valid = 1'b0;
    dram_tags[rw] = set_slot(dram_tags[rw], sl, tg, v);
    if (mb_v[idx] && mb_row[idx] == ROW_W'(rw)) mb_tags[idx] = set_slot(mb_tags[idx], sl, tg, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NROWS; r++) dram_tags[r] = MW'($urandom);
    for (int e = 0; e < ENTRIES; e++) begin mb_v[e] = 1'b0; mb_row[e] = '0; mb_tags[e] = '0; end
    repeat (3) @(negedge clk);
    chk(ld_ready && !mem_req_valid, "R1 reset state", {ld_ready, mem_req_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_ready && !mem_req_valid, "R1 idle after reset", {ld_ready, mem_req_valid}, 2'b10);

    // R1: first touch of any row reads its tags
    do_load(1, 5, 0, 0);
    // R3/R5: same row again now hits the buffer
    do_load(2, 5, 3, 0);
    // R9: update of a buffered row is seen by the next lookup
    do_upd(5, 1, 6, 1);
    do_load(6, 5, 1, 0);
    do_upd(5, 1, 6, 0);
    do_load(6, 5, 1, 0);
    // R9: update of an absent row (same index) leaves the buffer alone
    do_upd(13, 2, 4, 1);
    do_load(4, 5, 2, 0);
    do_load(4, 13, 2, 0);
    // R2: rows sharing index bits evict each other
    do_load(0, 2, 0, 0);
    do_load(0, 10, 0, 0);
    do_load(0, 2, 0, 1);

    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 9) < 3)
        do_upd($urandom_range(0, NROWS-1), $urandom_range(0, SLOTS-1),
               $urandom_range(0, 7), $urandom_range(0, 1) == 1);
      else
        do_load($urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, SLOTS-1),
                $urandom_range(0, 4) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule